// File: doc/BRIEF.md
# Round-Robin Shared Bus Arbiter

This block lets several Wishbone initiator ports share one downstream Wishbone port. A registered owner pointer chooses which initiator may use the shared port. The owner's request fields go straight through to the downstream side. The downstream response comes back to the owner only. Every other initiator sees an idle, stalled port.

Ownership rotates in round-robin order among the initiators whose cycle line is high. An owner keeps the port while it holds its cycle line together with either a lock or a strobe. This makes locked sequences and in-flight strobes atomic. Each initiator can be configured separately:

- It may address data in coarser units than the shared port. Its byte-select lines are then widened by replication.
- It may lack lock, cycle-type or burst-type lines. Fixed defaults then stand in for the missing lines.
- If the shared port has no stall line, a stall is derived from the acknowledge.

All initiators share the arbiter's address width and data width. Their granularity is equal to or coarser than the shared port's.

Top module: `rr_bus_arbiter`

## Requirements
- R1: Reset places ownership on initiator 0, so the first response after reset goes to initiator 0 whenever it requests.
- R2: When ownership is released, the search starts at the index just above the current owner, wraps past the highest index, and stops at the first initiator with its cycle line high. If none requests, ownership stays where it is.
- R3: Ownership does not move while the owner holds its cycle line high and also holds either its lock line or its strobe high.
- R4: When the owner lowers its cycle line while another initiator requests, ownership moves to the next requester at the following clock edge.
- R5: Acknowledge, error, retry and read data from the shared port reach only the owner. Every other initiator sees 0 on all four.
- R6: Every initiator except the owner sees stall 1. The owner sees the shared port's stall line.
- R7: With HAS_STALL = 0, the owner's stall is the inverse of the shared acknowledge.
- R8: An initiator with granularity log ratio g drives only the low SEL_W/2^g bits of its select slot; higher bits are ignored. Each driven bit i is copied onto shared select bits [i*2^g, (i+1)*2^g-1]. For g = 1 on a 4-bit shared select, 2'b10 becomes 4'b1100.
- R9: An initiator without a lock line presents its cycle line as lock. One without a cycle-type line presents the classic code 3'b000. One without a burst-type line presents the linear code 2'b00.
- R10: Shared cycle and strobe are 0 whenever no initiator has its cycle line high.
- R11: Address, write enable, write data, select, cycle type and burst type on the shared port are those of the owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_cyc | input | NUM_INIT | Cycle line of each initiator |
| init_stb | input | NUM_INIT | Strobe of each initiator |
| init_we | input | NUM_INIT | Write enable of each initiator |
| init_lock | input | NUM_INIT | Lock of each initiator (ignored where absent) |
| init_adr | input | NUM_INIT*ADDR_W | Word address per initiator |
| init_wdat | input | NUM_INIT*DATA_W | Write data per initiator |
| init_sel | input | NUM_INIT*SEL_W | Select slot per initiator |
| init_cti | input | NUM_INIT*3 | Cycle type per initiator (ignored where absent) |
| init_bte | input | NUM_INIT*2 | Burst type per initiator (ignored where absent) |
| init_rdat | output | NUM_INIT*DATA_W | Read data to each initiator |
| init_ack | output | NUM_INIT | Acknowledge to each initiator |
| init_err | output | NUM_INIT | Error to each initiator |
| init_rty | output | NUM_INIT | Retry to each initiator |
| init_stall | output | NUM_INIT | Stall to each initiator |
| sh_cyc | output | 1 | Shared cycle line |
| sh_stb | output | 1 | Shared strobe |
| sh_we | output | 1 | Shared write enable |
| sh_lock | output | 1 | Shared lock |
| sh_adr | output | ADDR_W | Shared word address |
| sh_wdat | output | DATA_W | Shared write data |
| sh_sel | output | SEL_W | Shared byte select |
| sh_cti | output | 3 | Shared cycle type |
| sh_bte | output | 2 | Shared burst type |
| sh_rdat | input | DATA_W | Shared read data |
| sh_ack | input | 1 | Shared acknowledge |
| sh_err | input | 1 | Shared error |
| sh_rty | input | 1 | Shared retry |
| sh_stall | input | 1 | Shared stall (unused when HAS_STALL = 0) |

## Verification
The bench builds the block with three initiators, a 32-bit data path and byte granularity.

Initiator 1 is given 16-bit granularity. This brings select widening and the ignored upper select bits within reach.

Initiator 2 is given no lock, cycle-type or burst-type line, so all three defaults can be observed on the shared port. Initiators 0 and 1 keep their lock lines, so a held lock and a held strobe can each be shown to block rotation.

A second instance, built with HAS_STALL = 0 and fed the same stimulus, makes the acknowledge-derived stall visible.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;
  typedef enum logic [2:0] {
    CYC_CLASSIC = 3'b000,
    CYC_CONST   = 3'b001,
    CYC_INCR    = 3'b010,
    CYC_LAST    = 3'b111
  } cyc_kind_e;

  typedef enum logic [1:0] {
    BURST_LINEAR = 2'b00,
    BURST_WRAP4  = 2'b01,
    BURST_WRAP8  = 2'b10,
    BURST_WRAP16 = 2'b11
  } burst_kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rrarb_adapt.sv
module rrarb_adapt
  import rrarb_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int GRAN_LOG = 0,
  parameter bit HAS_LOCK = 1,
  parameter bit HAS_CTI  = 1,
  parameter bit HAS_BTE  = 1
) (
  input  logic             cyc,
  input  logic             lock_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [2:0]       cti_in,
  input  logic [1:0]       bte_in,
  output logic             lock_eff,
  output logic [SEL_W-1:0] sel_wide,
  output logic [2:0]       cti_eff,
  output logic [1:0]       bte_eff
);
  localparam int REP = 1 << GRAN_LOG;

  // Each narrow select bit covers REP shared lanes.
  for (genvar j = 0; j < SEL_W; j++) begin : g_lane
    assign sel_wide[j] = sel_in[j / REP];
  end

  if (HAS_LOCK) begin : g_lock
    assign lock_eff = lock_in;
  end else begin : g_nolock
    assign lock_eff = cyc;
  end

  if (HAS_CTI) begin : g_cti
    assign cti_eff = cti_in;
  end else begin : g_nocti
    assign cti_eff = CYC_CLASSIC;
  end

  if (HAS_BTE) begin : g_bte
    assign bte_eff = bte_in;
  end else begin : g_nobte
    assign bte_eff = BURST_LINEAR;
  end
endmodule

// File: rtl/rrarb_grant.sv
module rrarb_grant #(
  parameter int NUM_INIT = 3,
  parameter int GW       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_INIT-1:0] req,
  input  logic [NUM_INIT-1:0] stb,
  input  logic [NUM_INIT-1:0] lock_eff,
  output logic [GW-1:0]       grant_q
);
  logic          hold;
  logic [GW-1:0] grant_d;
  logic          found;

  assign hold = req[grant_q] & (lock_eff[grant_q] | stb[grant_q]);

  always_comb begin
    grant_d = grant_q;
    found   = 1'b0;
    if (!hold) begin
      for (int k = 1; k <= NUM_INIT; k++) begin
        if (!found && req[(int'(grant_q) + k) % NUM_INIT]) begin
          grant_d = GW'((int'(grant_q) + k) % NUM_INIT);
          found   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else     grant_q <= grant_d;
  end
endmodule

// File: rtl/rrarb_mux.sv
module rrarb_mux #(
  parameter int NUM_INIT  = 3,
  parameter int GW        = 2,
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 4,
  parameter bit HAS_STALL = 1
) (
  input  logic [GW-1:0]              grant,
  input  logic [NUM_INIT-1:0]        cyc,
  input  logic [NUM_INIT-1:0]        stb,
  input  logic [NUM_INIT-1:0]        we,
  input  logic [NUM_INIT-1:0]        lock_eff,
  input  logic [NUM_INIT*ADDR_W-1:0] adr,
  input  logic [NUM_INIT*DATA_W-1:0] wdat,
  input  logic [NUM_INIT*SEL_W-1:0]  sel,
  input  logic [NUM_INIT*3-1:0]      cti,
  input  logic [NUM_INIT*2-1:0]      bte,
  output logic [NUM_INIT*DATA_W-1:0] rdat_o,
  output logic [NUM_INIT-1:0]        ack_o,
  output logic [NUM_INIT-1:0]        err_o,
  output logic [NUM_INIT-1:0]        rty_o,
  output logic [NUM_INIT-1:0]        stall_o,
  output logic                       d_cyc,
  output logic                       d_stb,
  output logic                       d_we,
  output logic                       d_lock,
  output logic [ADDR_W-1:0]          d_adr,
  output logic [DATA_W-1:0]          d_wdat,
  output logic [SEL_W-1:0]           d_sel,
  output logic [2:0]                 d_cti,
  output logic [1:0]                 d_bte,
  input  logic [DATA_W-1:0]          d_rdat,
  input  logic                       d_ack,
  input  logic                       d_err,
  input  logic                       d_rty,
  input  logic                       d_stall
);
  logic owner_cyc;
  logic own_stall;

  assign owner_cyc = cyc[grant];
  assign d_cyc  = owner_cyc;
  assign d_stb  = owner_cyc & stb[grant];
  assign d_we   = we[grant];
  assign d_lock = owner_cyc & lock_eff[grant];
  assign d_adr  = adr[grant*ADDR_W +: ADDR_W];
  assign d_wdat = wdat[grant*DATA_W +: DATA_W];
  assign d_sel  = sel[grant*SEL_W +: SEL_W];
  assign d_cti  = cti[grant*3 +: 3];
  assign d_bte  = bte[grant*2 +: 2];

  if (HAS_STALL) begin : g_stall
    assign own_stall = d_stall;
  end else begin : g_ackstall
    logic unused_stall;
    assign unused_stall = d_stall;
    assign own_stall    = ~d_ack;
  end

  for (genvar i = 0; i < NUM_INIT; i++) begin : g_resp
    logic own;
    assign own                         = (grant == GW'(i));
    assign ack_o[i]                    = own & d_ack;
    assign err_o[i]                    = own & d_err;
    assign rty_o[i]                    = own & d_rty;
    assign stall_o[i]                  = own ? own_stall : 1'b1;
    assign rdat_o[i*DATA_W +: DATA_W]  = own ? d_rdat : '0;
  end
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
  import rrarb_pkg::*;
#(
  parameter int                    NUM_INIT      = 3,
  parameter int                    ADDR_W        = 30,
  parameter int                    DATA_W        = 32,
  parameter int                    GRAN_W        = 8,
  parameter logic [4*NUM_INIT-1:0] INIT_GRAN_LOG = '0,
  parameter logic [NUM_INIT-1:0]   LOCK_MASK     = '1,
  parameter logic [NUM_INIT-1:0]   CTI_MASK      = '1,
  parameter logic [NUM_INIT-1:0]   BTE_MASK      = '1,
  parameter bit                    HAS_STALL     = 1,
  localparam int                   SEL_W         = DATA_W / GRAN_W,
  localparam int                   GW            = idx_width(NUM_INIT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_INIT-1:0]        init_cyc,
  input  logic [NUM_INIT-1:0]        init_stb,
  input  logic [NUM_INIT-1:0]        init_we,
  input  logic [NUM_INIT-1:0]        init_lock,
  input  logic [NUM_INIT*ADDR_W-1:0] init_adr,
  input  logic [NUM_INIT*DATA_W-1:0] init_wdat,
  input  logic [NUM_INIT*SEL_W-1:0]  init_sel,
  input  logic [NUM_INIT*3-1:0]      init_cti,
  input  logic [NUM_INIT*2-1:0]      init_bte,
  output logic [NUM_INIT*DATA_W-1:0] init_rdat,
  output logic [NUM_INIT-1:0]        init_ack,
  output logic [NUM_INIT-1:0]        init_err,
  output logic [NUM_INIT-1:0]        init_rty,
  output logic [NUM_INIT-1:0]        init_stall,
  output logic                       sh_cyc,
  output logic                       sh_stb,
  output logic                       sh_we,
  output logic                       sh_lock,
  output logic [ADDR_W-1:0]          sh_adr,
  output logic [DATA_W-1:0]          sh_wdat,
  output logic [SEL_W-1:0]           sh_sel,
  output logic [2:0]                 sh_cti,
  output logic [1:0]                 sh_bte,
  input  logic [DATA_W-1:0]          sh_rdat,
  input  logic                       sh_ack,
  input  logic                       sh_err,
  input  logic                       sh_rty,
  input  logic                       sh_stall
);
  logic [NUM_INIT-1:0]       lock_eff;
  logic [NUM_INIT*SEL_W-1:0] sel_wide;
  logic [NUM_INIT*3-1:0]     cti_eff;
  logic [NUM_INIT*2-1:0]     bte_eff;
  logic [GW-1:0]             grant_q;

  for (genvar i = 0; i < NUM_INIT; i++) begin : g_init
    rrarb_adapt #(
      .SEL_W   (SEL_W),
      .GRAN_LOG(int'(INIT_GRAN_LOG[4*i +: 4])),
      .HAS_LOCK(LOCK_MASK[i]),
      .HAS_CTI (CTI_MASK[i]),
      .HAS_BTE (BTE_MASK[i])
    ) u_adapt (
      .cyc     (init_cyc[i]),
      .lock_in (init_lock[i]),
      .sel_in  (init_sel[i*SEL_W +: SEL_W]),
      .cti_in  (init_cti[i*3 +: 3]),
      .bte_in  (init_bte[i*2 +: 2]),
      .lock_eff(lock_eff[i]),
      .sel_wide(sel_wide[i*SEL_W +: SEL_W]),
      .cti_eff (cti_eff[i*3 +: 3]),
      .bte_eff (bte_eff[i*2 +: 2])
    );
  end

  rrarb_grant #(
    .NUM_INIT(NUM_INIT),
    .GW      (GW)
  ) u_grant (
    .clk     (clk),
    .rst     (rst),
    .req     (init_cyc),
    .stb     (init_stb),
    .lock_eff(lock_eff),
    .grant_q (grant_q)
  );

  rrarb_mux #(
    .NUM_INIT (NUM_INIT),
    .GW       (GW),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .HAS_STALL(HAS_STALL)
  ) u_mux (
    .grant   (grant_q),
    .cyc     (init_cyc),
    .stb     (init_stb),
    .we      (init_we),
    .lock_eff(lock_eff),
    .adr     (init_adr),
    .wdat    (init_wdat),
    .sel     (sel_wide),
    .cti     (cti_eff),
    .bte     (bte_eff),
    .rdat_o  (init_rdat),
    .ack_o   (init_ack),
    .err_o   (init_err),
    .rty_o   (init_rty),
    .stall_o (init_stall),
    .d_cyc   (sh_cyc),
    .d_stb   (sh_stb),
    .d_we    (sh_we),
    .d_lock  (sh_lock),
    .d_adr   (sh_adr),
    .d_wdat  (sh_wdat),
    .d_sel   (sh_sel),
    .d_cti   (sh_cti),
    .d_bte   (sh_bte),
    .d_rdat  (sh_rdat),
    .d_ack   (sh_ack),
    .d_err   (sh_err),
    .d_rty   (sh_rty),
    .d_stall (sh_stall)
  );
endmodule

// File: rtl/rrarb_checker.sv
module rrarb_checker #(
  parameter int NUM_INIT = 3,
  parameter int GW       = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_INIT-1:0] init_cyc,
  input logic [NUM_INIT-1:0] init_stb,
  input logic [NUM_INIT-1:0] init_ack,
  input logic [NUM_INIT-1:0] init_stall,
  input logic                sh_cyc,
  input logic                sh_stb,
  input logic [GW-1:0]       grant_q
);
  logic [NUM_INIT-1:0] cyc_d;

  always_ff @(posedge clk) begin
    cyc_d <= init_cyc;
  end

  // R5
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(init_ack));

  // R6
  stall_others_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(init_stall) >= NUM_INIT - 1);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (init_cyc == '0) |-> (!sh_cyc && !sh_stb));

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (init_cyc[grant_q] && init_stb[grant_q]) |=> $stable(grant_q));

  // R2
  move_to_req_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(grant_q) |-> cyc_d[grant_q]);

  // R4
  drop_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_cyc[grant_q] && (init_cyc != '0)) |=> !$stable(grant_q));
endmodule

bind rr_bus_arbiter rrarb_checker #(
  .NUM_INIT(NUM_INIT),
  .GW      (GW)
) u_rrarb_checker (
  .clk       (clk),
  .rst       (rst),
  .init_cyc  (init_cyc),
  .init_stb  (init_stb),
  .init_ack  (init_ack),
  .init_stall(init_stall),
  .sh_cyc    (sh_cyc),
  .sh_stb    (sh_stb),
  .grant_q   (grant_q)
);

// File: tb/rr_bus_arbiter_bench.sv
module rr_bus_arbiter_bench;
  localparam int N  = 3;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0]    init_cyc, init_stb, init_we, init_lock;
  logic [N*AW-1:0] init_adr;
  logic [N*DW-1:0] init_wdat;
  logic [N*SW-1:0] init_sel;
  logic [N*3-1:0]  init_cti;
  logic [N*2-1:0]  init_bte;
  logic [N*DW-1:0] init_rdat, ns_rdat;
  logic [N-1:0]    init_ack, init_err, init_rty, init_stall;
  logic [N-1:0]    ns_ack, ns_err, ns_rty, ns_stall;
  logic            sh_cyc, sh_stb, sh_we, sh_lock;
  logic            ns_cyc, ns_stb, ns_we, ns_lock;
  logic [AW-1:0]   sh_adr, ns_adr;
  logic [DW-1:0]   sh_wdat, ns_wdat, sh_rdat;
  logic [SW-1:0]   sh_sel, ns_sel;
  logic [2:0]      sh_cti, ns_cti;
  logic [1:0]      sh_bte, ns_bte;
  logic            sh_ack, sh_err, sh_rty, sh_stall;

  rr_bus_arbiter #(
    .NUM_INIT(N), .ADDR_W(AW), .DATA_W(DW), .GRAN_W(8),
    .INIT_GRAN_LOG(12'h010), .LOCK_MASK(3'b011), .CTI_MASK(3'b011),
    .BTE_MASK(3'b011), .HAS_STALL(1)
  ) u_rr_bus_arbiter (
    .clk(clk), .rst(rst), .init_cyc(init_cyc), .init_stb(init_stb),
    .init_we(init_we), .init_lock(init_lock), .init_adr(init_adr),
    .init_wdat(init_wdat), .init_sel(init_sel), .init_cti(init_cti),
    .init_bte(init_bte), .init_rdat(init_rdat), .init_ack(init_ack),
    .init_err(init_err), .init_rty(init_rty), .init_stall(init_stall),
    .sh_cyc(sh_cyc), .sh_stb(sh_stb), .sh_we(sh_we), .sh_lock(sh_lock),
    .sh_adr(sh_adr), .sh_wdat(sh_wdat), .sh_sel(sh_sel), .sh_cti(sh_cti),
    .sh_bte(sh_bte), .sh_rdat(sh_rdat), .sh_ack(sh_ack), .sh_err(sh_err),
    .sh_rty(sh_rty), .sh_stall(sh_stall)
  );

  rr_bus_arbiter #(
    .NUM_INIT(N), .ADDR_W(AW), .DATA_W(DW), .GRAN_W(8),
    .INIT_GRAN_LOG(12'h010), .LOCK_MASK(3'b011), .CTI_MASK(3'b011),
    .BTE_MASK(3'b011), .HAS_STALL(0)
  ) u_nostall (
    .clk(clk), .rst(rst), .init_cyc(init_cyc), .init_stb(init_stb),
    .init_we(init_we), .init_lock(init_lock), .init_adr(init_adr),
    .init_wdat(init_wdat), .init_sel(init_sel), .init_cti(init_cti),
    .init_bte(init_bte), .init_rdat(ns_rdat), .init_ack(ns_ack),
    .init_err(ns_err), .init_rty(ns_rty), .init_stall(ns_stall),
    .sh_cyc(ns_cyc), .sh_stb(ns_stb), .sh_we(ns_we), .sh_lock(ns_lock),
    .sh_adr(ns_adr), .sh_wdat(ns_wdat), .sh_sel(ns_sel), .sh_cti(ns_cti),
    .sh_bte(ns_bte), .sh_rdat(sh_rdat), .sh_ack(sh_ack), .sh_err(sh_err),
    .sh_rty(sh_rty), .sh_stall(sh_stall)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst = 1'b1;
    init_cyc = '0; init_stb = '0; init_we = '0; init_lock = '0;
    init_adr = '0; init_wdat = '0; init_sel = '0; init_cti = '0; init_bte = '0;
    sh_rdat = '0; sh_ack = 1'b0; sh_err = 1'b0; sh_rty = 1'b0; sh_stall = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    init_stb = 3'b001;
    #1;
    chk("R10 idle cyc", 128'(sh_cyc), 128'(1'b0));
    chk("R10 idle stb", 128'(sh_stb), 128'(1'b0));
    init_cyc = 3'b101; init_stb = 3'b101; sh_ack = 1'b1;
    tick();
    chk("R1 first owner", 128'(init_ack), 128'(3'b001));
  endtask

  task automatic t_rotate();
    do_reset();
    sh_ack = 1'b1; init_stb = 3'b111;
    init_cyc = 3'b101; tick();
    chk("R2 step1", 128'(init_ack), 128'(3'b001));
    init_cyc = 3'b100; tick();
    chk("R4 drop to 2", 128'(init_ack), 128'(3'b100));
    init_cyc = 3'b011; tick();
    chk("R2 wrap to 0", 128'(init_ack), 128'(3'b001));
    init_cyc = 3'b110; tick();
    chk("R2 next is 1", 128'(init_ack), 128'(3'b010));
    init_cyc = 3'b101; tick();
    chk("R2 next is 2", 128'(init_ack), 128'(3'b100));
    init_cyc = 3'b000; tick();
    chk("R2 none keeps", 128'(init_ack), 128'(3'b100));
  endtask

  task automatic t_lock_hold();
    do_reset();
    sh_ack = 1'b1;
    init_cyc = 3'b011; init_lock = 3'b001; init_stb = 3'b010;
    tick();
    chk("R3 lock hold a", 128'(init_ack), 128'(3'b001));
    tick();
    chk("R3 lock hold b", 128'(init_ack), 128'(3'b001));
    init_lock = 3'b000; init_stb = 3'b011;
    tick();
    chk("R3 stb hold", 128'(init_ack), 128'(3'b001));
    init_stb = 3'b010;
    tick();
    chk("R3 release", 128'(init_ack), 128'(3'b010));
    init_cyc = 3'b001;
    tick();
    chk("R4 back to 0", 128'(init_ack), 128'(3'b001));
  endtask

  task automatic t_response();
    do_reset();
    init_cyc = 3'b011; init_stb = 3'b011; init_we = 3'b001; init_lock = 3'b001;
    init_adr[0 +: AW] = 30'h1FFFFFFF; init_adr[AW +: AW] = 30'h0000_0123;
    init_wdat[0 +: DW] = 32'h12345678; init_wdat[DW +: DW] = 32'h87654321;
    init_sel = 12'h00F; init_cti = 9'b000_000_010; init_bte = 6'b00_00_01;
    sh_rdat = 32'habcdef01; sh_ack = 1'b1; sh_err = 1'b1; sh_rty = 1'b1;
    tick();
    chk("R11 adr", 128'(sh_adr), 128'(30'h1FFFFFFF));
    chk("R11 we", 128'(sh_we), 128'(1'b1));
    chk("R11 wdat", 128'(sh_wdat), 128'(32'h12345678));
    chk("R11 sel", 128'(sh_sel), 128'(4'hF));
    chk("R11 cti", 128'(sh_cti), 128'(3'b010));
    chk("R11 bte", 128'(sh_bte), 128'(2'b01));
    chk("R5 rdat", 128'(init_rdat), 128'({32'h0, 32'h0, 32'habcdef01}));
    chk("R5 ack", 128'(init_ack), 128'(3'b001));
    chk("R5 err", 128'(init_err), 128'(3'b001));
    chk("R5 rty", 128'(init_rty), 128'(3'b001));
  endtask

  task automatic t_stall();
    do_reset();
    init_cyc = 3'b011; init_stb = 3'b011; sh_stall = 1'b0; sh_ack = 1'b0;
    tick();
    chk("R6 owner clear", 128'(init_stall), 128'(3'b110));
    chk("R7 ack low", 128'(ns_stall), 128'(3'b111));
    sh_stall = 1'b1; sh_ack = 1'b1;
    #1;
    chk("R6 owner stalled", 128'(init_stall), 128'(3'b111));
    chk("R7 ack high", 128'(ns_stall), 128'(3'b110));
  endtask

  task automatic t_sel_widen();
    do_reset();
    init_cyc = 3'b010; init_stb = 3'b010;
    init_sel[SW +: SW] = 4'b1110;
    tick();
    chk("R8 sel 10", 128'(sh_sel), 128'(4'b1100));
    init_sel[SW +: SW] = 4'b1001;
    #1;
    chk("R8 sel 01", 128'(sh_sel), 128'(4'b0011));
  endtask

  task automatic t_defaults();
    do_reset();
    init_cyc = 3'b100; init_stb = 3'b100; init_lock = 3'b000;
    init_cti = 9'b010_000_000; init_bte = 6'b01_00_00;
    tick();
    chk("R9 lock from cyc", 128'(sh_lock), 128'(1'b1));
    chk("R9 classic cti", 128'(sh_cti), 128'(3'b000));
    chk("R9 linear bte", 128'(sh_bte), 128'(2'b00));
    init_cyc = 3'b000;
    tick();
    chk("R10 drained", 128'({sh_cyc, sh_stb}), 128'(2'b00));
  endtask

  bit done = 1'b0;

  initial begin
    t_reset_state();
    t_rotate();
    t_lock_hold();
    t_response();
    t_stall();
    t_sel_widen();
    t_defaults();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule